// File: doc/BRIEF.md
# Masked Sticky Interrupt Aggregator

This block gathers single-cycle event pulses from a parameterised number of internal sources and presents them to a host as one level-sensitive interrupt line. Each source has a sticky pending bit, which sets on an event and holds until the host clears it. Each source also has an enable bit. The enable bit decides only whether that pending bit may drive the interrupt line.

The host reaches three registers through a simple synchronous port with address, write strobe, write data and combinational read data. The enable register is read/write. The pending register is read-only. The clear register is write-one-to-clear. In the usual service routine the host reads the pending register, writes the same value to the clear register, and then handles the sources it read. Any event that arrives in the meantime stays pending. The interrupt line is registered, so it follows the enabled pending bits one clock later.

Top module: `irq_aggregator`

## Requirements
- R1: A rising clock edge with `rst_n` low clears every enable bit and every pending bit, and drives `irq` low after that edge.
- R2: A high `src_evt[i]` at a rising edge sets pending bit i. The bit then stays 1 on later edges until it is cleared.
- R3: A pending bit latches whether or not its enable bit is set.
- R4: After each rising edge, `irq` equals the OR over all sources of (pending AND enable), as both stood just before that edge. `irq` is therefore a level with one clock of latency. A pending bit whose enable is 0 never raises `irq`, and enabling a source that is already pending raises `irq` one edge after the enable write.
- R5: A write to address 2 (the clear register) clears each pending bit whose write-data bit is 1. Bits written as 0 leave their pending bits unchanged.
- R6: If an event and a clear of the same bit occur at the same edge, the event wins and the pending bit stays 1.
- R7: Address map, with read data combinational from the current state: address 0 is the enable register, read/write. Address 1 is the pending register, which is read-only and ignores writes. Address 2 is the clear register, which always reads 0. Address 3 reads 0 and ignores writes.
- R8: Writing the value just read from the pending register to the clear register clears exactly those bits. With no new events, `irq` then falls one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| src_evt | input | SRC_COUNT | One-cycle event pulses, one bit per source |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | SRC_COUNT | Write data |
| reg_rdata | output | SRC_COUNT | Read data of the addressed register |
| irq | output | 1 | Level interrupt to the host |

## Verification
A wrong pending or enable bit reaches the ports in two ways. It shows on `reg_rdata` in the same cycle that the register is addressed. It shows on `irq` one edge after the enabled pending set changes. The bench models enable, pending and the registered line behaviourally and compares them on every clock, so a lost event, a missed clear or a wrong mask appears within one or two cycles. Directed sequences cover the cases that random traffic rarely produces: an event colliding with its own clear, a late enable, writes to read-only addresses, and write-back clears.

// File: rtl/irq_agg_pkg.sv
// Package: shared address encoding for the interrupt aggregator.
// Assumes a 2-bit register address bus.
package irq_agg_pkg;
    typedef enum logic [1:0] {
        ADDR_ENABLE  = 2'd0,
        ADDR_PENDING = 2'd1,
        ADDR_CLEAR   = 2'd2,
        ADDR_SPARE   = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/irq_pending_bank.sv
// Module: irq_pending_bank
// Holds one sticky pending bit per source. An event sets the bit and a
// clear-mask bit resets it. When both occur at the same edge, the event wins.
// Assumes clr_mask is already qualified by a write to the clear register.
module irq_pending_bank #(
    parameter int SRC_COUNT = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SRC_COUNT-1:0] src_evt,
    input  logic [SRC_COUNT-1:0] clr_mask,
    output logic [SRC_COUNT-1:0] pending
);
    for (genvar gi = 0; gi < SRC_COUNT; gi++) begin : g_bit
        // Per-source sticky flag: set beats clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pending[gi] <= 1'b0;
            else if (src_evt[gi])
                pending[gi] <= 1'b1;
            else if (clr_mask[gi])
                pending[gi] <= 1'b0;
        end

        // An event always leaves the bit set, even with a clear alongside.
        assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
            src_evt[gi] |=> pending[gi]);
        // Without a clear, a set bit holds.
        assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (pending[gi] && !clr_mask[gi]) |=> pending[gi]);
        // A clear with no competing event resets the bit.
        assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_mask[gi] && !src_evt[gi]) |=> !pending[gi]);
    end
endmodule

// File: rtl/irq_reg_port.sv
// Module: irq_reg_port
// Decodes host accesses. It keeps the enable register, produces the one-cycle
// clear mask, and muxes read data. Read data is combinational from the current
// state. Assumes a single-cycle write strobe with no handshake.
module irq_reg_port
    import irq_agg_pkg::*;
#(
    parameter int SRC_COUNT = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           reg_addr,
    input  logic                 reg_wr,
    input  logic [SRC_COUNT-1:0] reg_wdata,
    input  logic [SRC_COUNT-1:0] pending,
    output logic [SRC_COUNT-1:0] enable,
    output logic [SRC_COUNT-1:0] clr_mask,
    output logic [SRC_COUNT-1:0] reg_rdata
);
    reg_addr_e addr_e;
    assign addr_e = reg_addr_e'(reg_addr);

    // Enable mask register, written only at its own address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable <= '0;
        else if (reg_wr && addr_e == ADDR_ENABLE)
            enable <= reg_wdata;
    end

    // One-cycle write-one-to-clear mask.
    always_comb begin
        clr_mask = '0;
        if (reg_wr && addr_e == ADDR_CLEAR)
            clr_mask = reg_wdata;
    end

    // Read mux: the clear and spare addresses read as zero.
    always_comb begin
        unique case (addr_e)
            ADDR_ENABLE:  reg_rdata = enable;
            ADDR_PENDING: reg_rdata = pending;
            default:      reg_rdata = '0;
        endcase
    end

    // A write to any other address leaves the mask untouched.
    assert_mask_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && addr_e != ADDR_ENABLE) |=> $stable(enable));
    // A write to the enable address loads the written data.
    assert_mask_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && addr_e == ADDR_ENABLE) |=> enable == $past(reg_wdata));
endmodule

// File: rtl/irq_out_stage.sv
// Module: irq_out_stage
// Registers the OR of the enabled pending bits to form the host interrupt
// level. Assumes one clock of latency is acceptable to the host.
module irq_out_stage #(
    parameter int SRC_COUNT = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SRC_COUNT-1:0] pending,
    input  logic [SRC_COUNT-1:0] enable,
    output logic                 irq
);
    logic [SRC_COUNT-1:0] live;
    assign live = pending & enable;

    // Output flop for the level line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= |live;
    end

    // Reset drives the line low on the next edge.
    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |=> !irq);
endmodule

// File: rtl/irq_aggregator.sv
// Module: irq_aggregator (top)
// Combines sticky pending bits, an enable mask and a write-one-to-clear
// register into one level interrupt. Assumes src_evt is synchronous to clk.
module irq_aggregator #(
    parameter int SRC_COUNT = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SRC_COUNT-1:0] src_evt,
    input  logic [1:0]           reg_addr,
    input  logic                 reg_wr,
    input  logic [SRC_COUNT-1:0] reg_wdata,
    output logic [SRC_COUNT-1:0] reg_rdata,
    output logic                 irq
);
    logic [SRC_COUNT-1:0] pending;
    logic [SRC_COUNT-1:0] enable;
    logic [SRC_COUNT-1:0] clr_mask;

    irq_pending_bank #(.SRC_COUNT(SRC_COUNT)) u_bank (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt),
        .clr_mask(clr_mask), .pending(pending)
    );

    irq_reg_port #(.SRC_COUNT(SRC_COUNT)) u_port (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .pending(pending), .enable(enable),
        .clr_mask(clr_mask), .reg_rdata(reg_rdata)
    );

    irq_out_stage #(.SRC_COUNT(SRC_COUNT)) u_out (
        .clk(clk), .rst_n(rst_n), .pending(pending),
        .enable(enable), .irq(irq)
    );

    // The line tracks the enabled pending set with exactly one edge of delay.
    assert_level_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq == $past(|(pending & enable)));
    // Reset empties the status and the mask.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (pending == '0 && enable == '0));
endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
    localparam int N = 8;
    localparam time CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_evt = '0;
    logic [1:0]   reg_addr = '0;
    logic         reg_wr = 1'b0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic         irq;

    // Behavioural reference state.
    logic [N-1:0] m_en = '0;
    logic [N-1:0] m_pend = '0;
    logic         m_irq = 1'b0;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    irq_aggregator #(.SRC_COUNT(N)) i_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, check reads, model the edge, check irq.
    task automatic cycle(input logic [N-1:0] e, input logic [1:0] a,
                         input logic w, input logic [N-1:0] d);
        logic [N-1:0] exp_rd;
        logic [N-1:0] clr;
        src_evt = e; reg_addr = a; reg_wr = w; reg_wdata = d;
        #1;
        exp_rd = (a == 2'd0) ? m_en : (a == 2'd1) ? m_pend : '0;
        if (rst_n) chk("R7 read data", reg_rdata, exp_rd);
        @(posedge clk);
        if (!rst_n) begin
            m_en = '0; m_pend = '0; m_irq = 1'b0;
        end else begin
            m_irq = |(m_pend & m_en);
            clr = (w && a == 2'd2) ? d : '0;
            m_pend = (m_pend & ~clr) | e;
            if (w && a == 2'd0) m_en = d;
        end
        @(negedge clk);
        chk("R4 irq level", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, m_irq});
    endtask

    task automatic idle(); cycle('0, 2'd3, 1'b0, '0); endtask

    // Directed read: compare against a hand-computed value.
    task automatic peek(input logic [1:0] a, input logic [N-1:0] exp, input string tag);
        reg_addr = a; reg_wr = 1'b0; src_evt = '0;
        #1;
        chk(tag, reg_rdata, exp);
        cycle('0, a, 1'b0, '0);
    endtask

    initial begin
        @(negedge clk);
        repeat (3) idle();
        chk("R1 reset irq", {{(N-1){1'b0}}, irq}, '0);
        rst_n = 1'b1;
        peek(2'd0, 8'h00, "R1 enable after reset");
        peek(2'd1, 8'h00, "R1 pending after reset");

        // R3: latch while disabled; no irq.
        cycle(8'h01, 2'd3, 1'b0, '0);
        idle(); idle();
        peek(2'd1, 8'h01, "R3 pending latched while disabled");
        chk("R4 disabled source stays quiet", {{(N-1){1'b0}}, irq}, '0);

        // R4: late enable raises irq one edge after the write.
        cycle('0, 2'd0, 1'b1, 8'h01);
        chk("R4 irq not yet", {{(N-1){1'b0}}, irq}, '0);
        idle();
        chk("R4 late enable raises irq", {{(N-1){1'b0}}, irq}, 8'h01);

        // R7: writes to pending and spare are ignored.
        cycle('0, 2'd1, 1'b1, 8'h00);
        cycle('0, 2'd3, 1'b1, 8'hFF);
        peek(2'd1, 8'h01, "R7 pending is read-only");
        peek(2'd0, 8'h01, "R7 spare write ignored");
        peek(2'd2, 8'h00, "R7 clear reads zero");

        // R6: event and clear of bit 3 at the same edge.
        cycle(8'h08, 2'd3, 1'b0, '0);
        cycle(8'h08, 2'd2, 1'b1, 8'h08);
        peek(2'd1, 8'h09, "R6 event beats clear");

        // R8: write back the read value.
        cycle('0, 2'd2, 1'b1, 8'h09);
        peek(2'd1, 8'h00, "R8 write-back clears all read");
        chk("R8 irq falls", {{(N-1){1'b0}}, irq}, '0);

        // R5: partial clear.
        cycle(8'h0F, 2'd3, 1'b0, '0);
        cycle('0, 2'd2, 1'b1, 8'h05);
        peek(2'd1, 8'h0A, "R5 zero bits kept");

        // R2: sticky over many idle cycles.
        repeat (5) idle();
        peek(2'd1, 8'h0A, "R2 sticky hold");

        // Random traffic with occasional reset and write-back clears.
        for (int k = 0; k < 3000; k++) begin
            logic [N-1:0] e;
            e = N'($urandom & $urandom & $urandom);
            rst_n = ($urandom % 200) != 0;
            if (($urandom % 8) == 0)
                cycle(e, 2'd2, 1'b1, m_pend);
            else
                cycle(e, 2'($urandom), 1'($urandom), N'($urandom));
        end
        rst_n = 1'b1;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule